// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block sits between the CPU register bus and an on-chip flash macro. It decides when the macro may be in program, erase, program-verify or erase-verify mode. Software arms a mode by writing a control register. A master write-enable bit in that register gates every mode. Two erase-enable registers, one bit per flash block, decide which blocks an erase may touch.

The block watches for CPU behaviour that is illegal while the array is being programmed or erased:
- a read or fetch that hits the flash address range,
- entry to exception handling,
- a sleep event,
- handing the bus to a DMA master.

Any of these events latches a sticky error flag and stops the active program or erase in the same cycle. After that, software may still enter the verify modes, but it cannot start program or erase again until a reset or a standby entry clears the flag. The flash cell timing and the CPU are outside this block.

Top module: `flash_guard`

## Requirements
- R1: An active-low reset clears every register. A one-cycle standby pulse clears the control register, the error flag and erase-enable register A, and keeps erase-enable register B. While reset or standby is asserted, no mode output is active.
- R2: The register map is as follows. Select 0 is control: bit0 write-enable, bit1 program, bit2 erase, bit3 program-verify, bit4 erase-verify. Select 1 is status, with the error flag in bit 7. Select 2 is erase-enable A (blocks 0-7). Select 3 is erase-enable B (blocks 8-15). Reads are combinational on `bus_sel`, and unused bits read 0.
- R3: While control bit0 is 0, none of the four mode outputs is active, whatever the other control bits hold.
- R4: Program is active only when write-enable and program are set, and erase and program-verify are clear. Erase is active only when write-enable and erase are set, and program and erase-verify are clear. Each verify mode is active when write-enable and its own verify bit are set.
- R5: `blk_sel` equals {erase-enable B, erase-enable A} while erase mode is active, and is zero otherwise. When both registers are zero, no line is asserted.
- R6: A CPU read or fetch strobe together with `flash_hit`, during program or erase, sets the error flag. The same strobes without `flash_hit` do not.
- R7: An exception-entry, sleep or DMA-grant pulse during program or erase sets the error flag. The same pulses while neither mode is active do not.
- R8: Program and erase outputs go low in the same cycle as the triggering event. The control and erase-enable registers keep their values.
- R9: While the error flag is set, rewriting the program or erase bit does not re-enter that mode. Setting a verify bit with write-enable still enters the matching verify mode.
- R10: Only reset or standby clears the error flag. Bus writes to the status register have no effect. Reset never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby entry, synchronous clear |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_sel` |
| cpu_rd | input | 1 | CPU data or vector read strobe |
| cpu_fetch | input | 1 | CPU instruction fetch strobe |
| flash_hit | input | 1 | Current CPU access falls in the flash range |
| exc_entry | input | 1 | Non-reset exception handling begins |
| sleep_evt | input | 1 | Sleep event |
| dma_grant | input | 1 | Bus handed to a DMA or transfer master |
| prog_on | output | 1 | Program mode to flash macro |
| erase_on | output | 1 | Erase mode to flash macro |
| pver_on | output | 1 | Program-verify mode |
| ever_on | output | 1 | Erase-verify mode |
| blk_sel | output | 16 | Per-block erase select |

## Verification
The mode decode is swept over all 32 control values with a fixed, non-symmetric pair of erase-enable patterns. This separates the write-enable gating, the program/erase exclusion and the verify suppression, and a swapped half would show up in `blk_sel`. Each of the five error triggers is applied once, alternating between program and erase. Each is paired with a non-trigger twin: the strobe without `flash_hit`, or the pulse while idle. That pairing separates a correct qualifier from a missing one. Retry-after-error, status writes, standby retention of register B and a reset taken mid-program complete the set.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;
    localparam int ERR_BIT = 7;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_BLKA = 2'd2,
        SEL_BLKB = 2'd3
    } reg_sel_e;

    // control bits, LSB first: wen, pg, er, pv, ev
    typedef struct packed {
        logic ev;
        logic pv;
        logic er;
        logic pg;
        logic wen;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t             ctrl;
        logic              err;
        logic [DATA_W-1:0] blka;
        logic [DATA_W-1:0] blkb;
    } regs_t;

    typedef struct packed {
        logic prog;
        logic erase;
        logic pver;
        logic ever;
    } modes_t;

endpackage

// File: rtl/fg_regfile.sv
module fg_regfile
    import flash_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              bus_we,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              err_set,
    output regs_t             regs
);

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            case (reg_sel_e'(bus_sel))
                SEL_CTRL: regs_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                SEL_BLKA: regs_d.blka = bus_wdata;
                SEL_BLKB: regs_d.blkb = bus_wdata;
                default:  ;
            endcase
        end
        if (err_set) begin
            regs_d.err = 1'b1;
        end
        if (standby) begin
            regs_d.ctrl = '0;
            regs_d.err  = 1'b0;
            regs_d.blka = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/fg_err_detect.sv
module fg_err_detect (
    input  logic cpu_rd,
    input  logic cpu_fetch,
    input  logic flash_hit,
    input  logic exc_entry,
    input  logic sleep_evt,
    input  logic dma_grant,
    output logic trig
);

    localparam int N_SRC = 4;

    logic [N_SRC-1:0] src;

    always_comb begin
        src[0] = (cpu_rd | cpu_fetch) & flash_hit;
        src[1] = exc_entry;
        src[2] = sleep_evt;
        src[3] = dma_grant;
        trig   = |src;
    end

endmodule

// File: rtl/fg_mode_decode.sv
module fg_mode_decode
    import flash_guard_pkg::*;
(
    input  regs_t               regs,
    input  logic                standby,
    input  logic                rst_n,
    input  logic                trig,
    output logic                busy,
    output modes_t              modes,
    output logic [2*DATA_W-1:0] blk_sel
);

    logic raw_prog, raw_erase, live;

    always_comb begin
        live      = rst_n & ~standby;
        raw_prog  = regs.ctrl.wen & regs.ctrl.pg & ~regs.ctrl.er & ~regs.ctrl.pv;
        raw_erase = regs.ctrl.wen & regs.ctrl.er & ~regs.ctrl.pg & ~regs.ctrl.ev;
        busy      = (raw_prog | raw_erase) & ~regs.err & live;

        modes.prog  = raw_prog  & ~regs.err & ~trig & live;
        modes.erase = raw_erase & ~regs.err & ~trig & live;
        modes.pver  = regs.ctrl.wen & regs.ctrl.pv & live;
        modes.ever  = regs.ctrl.wen & regs.ctrl.ev & live;

        blk_sel = modes.erase ? {regs.blkb, regs.blka} : '0;
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              cpu_rd,
    input  logic              cpu_fetch,
    input  logic              flash_hit,
    input  logic              exc_entry,
    input  logic              sleep_evt,
    input  logic              dma_grant,
    output logic              prog_on,
    output logic              erase_on,
    output logic              pver_on,
    output logic              ever_on,
    output logic [15:0]       blk_sel
);

    regs_t  regs;
    modes_t modes;
    logic   trig, busy, err_set, err_q, wen_q;

    fg_err_detect u_det (
        .cpu_rd    (cpu_rd),
        .cpu_fetch (cpu_fetch),
        .flash_hit (flash_hit),
        .exc_entry (exc_entry),
        .sleep_evt (sleep_evt),
        .dma_grant (dma_grant),
        .trig      (trig)
    );

    fg_mode_decode u_dec (
        .regs    (regs),
        .standby (standby),
        .rst_n   (rst_n),
        .trig    (trig),
        .busy    (busy),
        .modes   (modes),
        .blk_sel (blk_sel)
    );

    assign err_set = trig & busy;

    fg_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (standby),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .err_set   (err_set),
        .regs      (regs)
    );

    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_sel))
            SEL_CTRL: bus_rdata[CTRL_W-1:0] = regs.ctrl;
            SEL_STAT: bus_rdata[ERR_BIT]    = regs.err;
            SEL_BLKA: bus_rdata             = regs.blka;
            SEL_BLKB: bus_rdata             = regs.blkb;
            default:  bus_rdata             = '0;
        endcase
    end

    assign prog_on  = modes.prog;
    assign erase_on = modes.erase;
    assign pver_on  = modes.pver;
    assign ever_on  = modes.ever;
    assign err_q    = regs.err;
    assign wen_q    = regs.ctrl.wen;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        standby,
    input logic        err_q,
    input logic        wen_q,
    input logic        prog_on,
    input logic        erase_on,
    input logic        pver_on,
    input logic        ever_on,
    input logic [15:0] blk_sel
);

    // R4
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_on && erase_on));

    // R3
    wen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wen_q |-> !(prog_on || erase_on || pver_on || ever_on));

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !standby) |=> err_q);

    // R9
    err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !(prog_on || erase_on));

    // R8
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(!prog_on && !erase_on));

    // R5
    sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_sel != 16'h0) |-> erase_on);

    // R1
    stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !err_q);

endmodule

bind flash_guard flash_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby  (standby),
    .err_q    (err_q),
    .wen_q    (wen_q),
    .prog_on  (prog_on),
    .erase_on (erase_on),
    .pver_on  (pver_on),
    .ever_on  (ever_on),
    .blk_sel  (blk_sel)
);

// File: tb/flash_guard_test.sv
module flash_guard_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        cpu_rd = 1'b0, cpu_fetch = 1'b0, flash_hit = 1'b0;
    logic        exc_entry = 1'b0, sleep_evt = 1'b0, dma_grant = 1'b0;
    logic        prog_on, erase_on, pver_on, ever_on;
    logic [15:0] blk_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [7:0] PAT_A = 8'h3C;
    localparam logic [7:0] PAT_B = 8'hA5;

    always #5 clk = ~clk;

    flash_guard uut (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cpu_rd(cpu_rd), .cpu_fetch(cpu_fetch), .flash_hit(flash_hit),
        .exc_entry(exc_entry), .sleep_evt(sleep_evt), .dma_grant(dma_grant),
        .prog_on(prog_on), .erase_on(erase_on), .pver_on(pver_on),
        .ever_on(ever_on), .blk_sel(blk_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] data);
        bus_sel = sel;
        #1;
        data = bus_rdata;
    endtask

    function automatic logic [3:0] modes_now();
        return {prog_on, erase_on, pver_on, ever_on};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {cpu_rd, cpu_fetch, flash_hit, exc_entry, sleep_evt, dma_grant} = '0;
        standby = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_trig(input int k);
        case (k)
            0: begin cpu_rd = 1'b1; flash_hit = 1'b1; end
            1: begin cpu_fetch = 1'b1; flash_hit = 1'b1; end
            2: exc_entry = 1'b1;
            3: sleep_evt = 1'b1;
            default: dma_grant = 1'b1;
        endcase
    endtask

    task automatic clear_trig();
        {cpu_rd, cpu_fetch, flash_hit, exc_entry, sleep_evt, dma_grant} = '0;
    endtask

    initial begin
        logic [7:0] d;
        do_reset();

        // R1 / R2: reset state of every register and of the modes
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), d);
            chk("R1 reset reg", {24'd0, d}, 32'd0);
        end
        chk("R1 reset modes", {28'd0, modes_now()}, 32'd0);

        // R2: readback and unused bits
        wr(2'd0, 8'hFF);
        rd(2'd0, d);
        chk("R2 ctrl readback", {24'd0, d}, 32'h1F);
        wr(2'd2, PAT_A);
        wr(2'd3, PAT_B);
        rd(2'd2, d); chk("R2 blkA", {24'd0, d}, {24'd0, PAT_A});
        rd(2'd3, d); chk("R2 blkB", {24'd0, d}, {24'd0, PAT_B});

        // R3 R4 R5: sweep every control value
        for (int v = 0; v < 32; v++) begin
            logic w, p, e, pv, ev, xp, xe;
            w = v[0]; p = v[1]; e = v[2]; pv = v[3]; ev = v[4];
            xp = w & p & ~e & ~pv;
            xe = w & e & ~p & ~ev;
            wr(2'd0, 8'(v));
            #1;
            chk("R3 R4 mode sweep", {28'd0, modes_now()},
                {28'd0, xp, xe, w & pv, w & ev});
            chk("R5 block select", {16'd0, blk_sel},
                {16'd0, (xe ? {PAT_B, PAT_A} : 16'h0)});
        end

        // R5: all-zero erase enables protect every block
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h05);
        #1;
        chk("R5 erase on with zero enables", {31'd0, erase_on}, 32'd1);
        chk("R5 zero enables no select", {16'd0, blk_sel}, 32'd0);

        // R6 R7 R8 R9 R10: each trigger, alternating program and erase
        for (int k = 0; k < 5; k++) begin
            logic [7:0] base, vbit;
            base = (k % 2 == 0) ? 8'h03 : 8'h05;
            vbit = (k % 2 == 0) ? 8'h09 : 8'h11;
            do_reset();
            wr(2'd2, PAT_A);
            wr(2'd3, PAT_B);
            wr(2'd0, base);

            // non-triggering twin first
            @(negedge clk);
            if (k < 2) begin
                if (k == 0) cpu_rd = 1'b1; else cpu_fetch = 1'b1;
                flash_hit = 1'b0;
            end
            @(negedge clk);
            clear_trig();
            rd(2'd1, d);
            if (k < 2) chk("R6 out-of-range access no error", {24'd0, d}, 32'd0);

            // real trigger
            @(negedge clk);
            pulse_trig(k);
            #1;
            chk("R8 mode drops in trigger cycle", {30'd0, prog_on, erase_on}, 32'd0);
            @(negedge clk);
            clear_trig();
            rd(2'd1, d);
            chk(k < 2 ? "R6 flash access sets error" : "R7 event sets error",
                {24'd0, d}, 32'h80);
            rd(2'd0, d); chk("R8 ctrl kept", {24'd0, d}, {24'd0, base});
            rd(2'd2, d); chk("R8 blkA kept", {24'd0, d}, {24'd0, PAT_A});
            rd(2'd3, d); chk("R8 blkB kept", {24'd0, d}, {24'd0, PAT_B});
            chk("R8 modes off after error", {28'd0, modes_now()}, 32'd0);

            wr(2'd0, 8'h01);
            wr(2'd0, base);
            #1;
            chk("R9 no re-entry", {30'd0, prog_on, erase_on}, 32'd0);
            wr(2'd0, vbit);
            #1;
            chk("R9 verify allowed", {30'd0, pver_on, ever_on},
                (k % 2 == 0) ? 32'd2 : 32'd1);

            wr(2'd1, 8'h00);
            rd(2'd1, d);
            chk("R10 status write ignored", {24'd0, d}, 32'h80);
        end

        // R7: events while idle do not set the error
        do_reset();
        wr(2'd0, 8'h01);
        @(negedge clk);
        exc_entry = 1'b1; sleep_evt = 1'b1; dma_grant = 1'b1;
        cpu_rd = 1'b1; flash_hit = 1'b1;
        @(negedge clk);
        clear_trig();
        rd(2'd1, d);
        chk("R7 idle events no error", {24'd0, d}, 32'd0);

        // R1 / R10: standby clears error, ctrl and A, keeps B
        wr(2'd2, PAT_A);
        wr(2'd3, PAT_B);
        wr(2'd0, 8'h03);
        @(negedge clk);
        sleep_evt = 1'b1;
        @(negedge clk);
        sleep_evt = 1'b0;
        rd(2'd1, d); chk("R7 sleep sets error", {24'd0, d}, 32'h80);
        standby = 1'b1;
        #1;
        chk("R1 modes off in standby", {28'd0, modes_now()}, 32'd0);
        @(negedge clk);
        standby = 1'b0;
        rd(2'd1, d); chk("R10 standby clears error", {24'd0, d}, 32'd0);
        rd(2'd0, d); chk("R1 standby clears ctrl", {24'd0, d}, 32'd0);
        rd(2'd2, d); chk("R1 standby clears blkA", {24'd0, d}, 32'd0);
        rd(2'd3, d); chk("R1 standby keeps blkB", {24'd0, d}, {24'd0, PAT_B});

        // R10: reset taken during program never sets the error
        wr(2'd0, 8'h03);
        #1;
        chk("R4 program active", {31'd0, prog_on}, 32'd1);
        do_reset();
        rd(2'd1, d);
        chk("R10 reset leaves error clear", {24'd0, d}, 32'd0);
        chk("R1 modes off after reset", {28'd0, modes_now()}, 32'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule